// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits in a synchronous clock domain and serves single-beat read and write requests for an external asynchronous static RAM of 524,288 bytes (19-bit address, 8-bit data). The RAM has active-low chip, write and output enables. A request is offered on a ready/valid port. The controller then drives the address, the three strobes and a split tri-state data bus (out value, out enable, in value) through a fixed sequence of phases. A completed read returns its byte with a one-cycle valid pulse.

Each phase lasts a whole number of clock cycles. That number is worked out at elaboration from two parameters: the clock period in picoseconds and a speed-grade index. The cycle count is the ceiling of the grade's minimum time divided by the clock period, and never less than one. After a read, the controller tracks how long the RAM may keep driving the data pins. A write that follows too soon waits in a turnaround phase before the controller drives the bus. The memory needs no clock and no refresh, so every cycle on the pins comes from a request.

Top module: `sram_ctl_top`

## Requirements
- R1: During reset and in the idle state, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only in the idle state. A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. No new request is accepted until the current transaction has finished.
- R3: A read holds `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 for exactly ACC cycles, starting in the cycle after acceptance. ACC = ceil(read cycle time / clock period).
- R4: `rd_data` is the value on `mem_dq_in` at the edge that ends the read access. `rd_valid` is 1 for exactly one cycle, which is the cycle right after the access cycles. In that cycle `mem_oe_n` is already 1.
- R5: A write runs in three phases. First, one setup cycle with `mem_ce_n`=0, `mem_we_n`=1 and the data driven. Next, PULSE cycles with `mem_we_n`=0. Last, REC cycles with `mem_we_n`=1, `mem_ce_n`=0 and the data still driven. `mem_oe_n` stays 1 throughout. PULSE = ceil(write pulse time / period). REC = ceil((write cycle time − write pulse time) / period).
- R6: Whenever `mem_we_n` is 0, `mem_ce_n` is 0, `mem_oe_n` is 1 and `mem_dq_oe` is 1.
- R7: After a read, `mem_dq_oe` does not rise until TURN full cycles have passed with `mem_oe_n` high. TURN = ceil(output float time / period). A write offered right after a read spends the cycles still missing in a turnaround phase, with all strobes high and the bus undriven.
- R8: A write accepted once the float time has already elapsed enters its setup phase in the cycle after acceptance, with no turnaround cycle.
- R9: For a whole transaction, `mem_addr` equals the accepted address and `mem_dq_out` equals the accepted write data. Changes on `req_addr`, `req_wdata` or `req_valid` after acceptance have no effect.
- R10: Every phase lasts at least one cycle. `GRADE` 0..5 selects the 10/12/15/17/20/25 ns grade. For those grades, the write pulse is 7/8/10/12/13/15 ns and the output float time is 5/6/7/7/8/10 ns. With a 20 ns clock and grade 0, every phase is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address of the request |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds read result |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 19 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data pins |
| mem_dq_oe | output | 1 | 1 = controller drives the data pins |
| mem_dq_in | input | 8 | Value sampled from the data pins |

## Verification
A stuck or wrongly advanced phase counter shows at the pins within one transaction. The low time of `mem_oe_n` or `mem_we_n` then differs from the computed cycle count, and for reads `rd_valid` arrives early or late. A float tracker that loads wrongly or never counts down shows on the first write that follows a read. The data enable then rises before, or long after, the required number of cycles with `mem_oe_n` high, or an idle-separated write still spends a turnaround cycle. A wrong capture edge or stale request latch shows in the next read of the same address as a byte that differs from what was written.

// File: rtl/sram_ctl_pkg.sv
// Shared state type and timing helpers for the static RAM strobe controller.
// Assumes times are given in picoseconds and a grade index in 0..5.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_CAP,
        ST_TURN,
        ST_WR_SET,
        ST_WR_PULSE,
        ST_WR_REC
    } ctl_state_t;

    // Minimum read/write cycle time of a grade (equals address access time).
    function automatic int unsigned grade_cycle_ps(input int unsigned g);
        case (g)
            0:       return 10000;
            1:       return 12000;
            2:       return 15000;
            3:       return 17000;
            4:       return 20000;
            default: return 25000;
        endcase
    endfunction

    // Minimum write strobe width of a grade.
    function automatic int unsigned grade_pulse_ps(input int unsigned g);
        case (g)
            0:       return 7000;
            1:       return 8000;
            2:       return 10000;
            3:       return 12000;
            4:       return 13000;
            default: return 15000;
        endcase
    endfunction

    // Longest time the RAM may still drive its pins after a deselect.
    function automatic int unsigned grade_float_ps(input int unsigned g);
        case (g)
            0:       return 5000;
            1:       return 6000;
            2:       return 7000;
            3:       return 7000;
            4:       return 8000;
            default: return 10000;
        endcase
    endfunction

    // Ceiling division of a time by the clock period, never below one cycle.
    function automatic int unsigned phase_cycles(input int unsigned t_ps,
                                                 input int unsigned clk_ps);
        int unsigned q;
        q = (t_ps + clk_ps - 1) / clk_ps;
        return (q < 1) ? 1 : q;
    endfunction

endpackage

// File: rtl/sram_ctl_float.sv
// Bus float tracker: counts the cycles after the output enable is released
// during which the RAM may still drive the data pins.
// Assumes oe_release pulses on the edge where the read access ends.
module sram_ctl_float #(
    parameter int unsigned TURN_CYC = 1,
    localparam int unsigned FLT_W   = $clog2(TURN_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_release,
    output logic float_busy
);

    logic [FLT_W-1:0] flt_q;

    // Load the float window on release, then count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else if (oe_release) begin
            flt_q <= FLT_W'(TURN_CYC);
        end else if (flt_q != '0) begin
            flt_q <= flt_q - FLT_W'(1);
        end
    end

    // More than one cycle left means driving at the next edge is too early.
    assign float_busy = (flt_q > FLT_W'(1));

endmodule

// File: rtl/sram_ctl_fsm.sv
// Transaction sequencer: walks read and write phases, each held for its
// computed number of cycles by one shared down-counter.
// Assumes every phase length is at least one cycle.
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ACC_CYC   = 1,
    parameter int unsigned SET_CYC   = 1,
    parameter int unsigned PULSE_CYC = 1,
    parameter int unsigned REC_CYC   = 1,
    parameter int unsigned CNT_W     = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       float_busy,
    output ctl_state_t state,
    output logic       req_ready,
    output logic       accept,
    output logic       access_done
);

    ctl_state_t       state_q;
    ctl_state_t       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             cnt_zero;

    assign cnt_zero    = (cnt_q == '0);
    assign req_ready   = (state_q == ST_IDLE);
    assign accept      = req_valid && req_ready;
    assign access_done = (state_q == ST_RD_ACC) && cnt_zero;
    assign state       = state_q;

    // Next phase and the counter value that times it.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_zero ? cnt_q : cnt_q - CNT_W'(1);
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write) begin
                        state_d = ST_RD_ACC;
                        cnt_d   = CNT_W'(ACC_CYC - 1);
                    end else if (float_busy) begin
                        state_d = ST_TURN;
                    end else begin
                        state_d = ST_WR_SET;
                        cnt_d   = CNT_W'(SET_CYC - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (cnt_zero) state_d = ST_RD_CAP;
            end
            ST_RD_CAP: begin
                state_d = ST_IDLE;
            end
            ST_TURN: begin
                if (!float_busy) begin
                    state_d = ST_WR_SET;
                    cnt_d   = CNT_W'(SET_CYC - 1);
                end
            end
            ST_WR_SET: begin
                if (cnt_zero) begin
                    state_d = ST_WR_PULSE;
                    cnt_d   = CNT_W'(PULSE_CYC - 1);
                end
            end
            ST_WR_PULSE: begin
                if (cnt_zero) begin
                    state_d = ST_WR_REC;
                    cnt_d   = CNT_W'(REC_CYC - 1);
                end
            end
            ST_WR_REC: begin
                if (cnt_zero) state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State and phase counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/sram_ctl_datapath.sv
// Request latch, read capture and pin decode for the strobe controller.
// Assumes state comes straight from the sequencer's state register.
module sram_ctl_datapath
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_state_t        state,
    input  logic              accept,
    input  logic              access_done,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Hold the accepted address and write data for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the data pins on the edge that closes the access window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (access_done) begin
            rdata_q <= mem_dq_in;
        end
    end

    // Strobe and bus-drive decode from the registered state.
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state)
            ST_RD_ACC: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_WR_SET, ST_WR_REC: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            default: begin
                mem_ce_n = 1'b1;
            end
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rd_data    = rdata_q;
    assign rd_valid   = (state == ST_RD_CAP);

endmodule

// File: rtl/sram_ctl_top.sv
// Static RAM strobe controller top: derives phase lengths from the clock
// period and grade, then joins sequencer, float tracker and datapath.
// Assumes CLK_PERIOD_PS > 0 and GRADE in 0..5 (larger values act as 5).
module sram_ctl_top
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 20000,
    parameter int unsigned GRADE         = 0,
    parameter int unsigned ADDR_W        = 19,
    parameter int unsigned DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned T_CYC_PS   = grade_cycle_ps(GRADE);
    localparam int unsigned T_PULSE_PS = grade_pulse_ps(GRADE);
    localparam int unsigned T_FLT_PS   = grade_float_ps(GRADE);

    localparam int unsigned ACC_CYC   = phase_cycles(T_CYC_PS, CLK_PERIOD_PS);
    localparam int unsigned SET_CYC   = phase_cycles(0, CLK_PERIOD_PS);
    localparam int unsigned PULSE_CYC = phase_cycles(T_PULSE_PS, CLK_PERIOD_PS);
    localparam int unsigned REC_CYC   = phase_cycles(T_CYC_PS - T_PULSE_PS, CLK_PERIOD_PS);
    localparam int unsigned TURN_CYC  = phase_cycles(T_FLT_PS, CLK_PERIOD_PS);

    localparam int unsigned MAX_AP  = (ACC_CYC > PULSE_CYC) ? ACC_CYC : PULSE_CYC;
    localparam int unsigned MAX_RS  = (REC_CYC > SET_CYC) ? REC_CYC : SET_CYC;
    localparam int unsigned MAX_CYC = (MAX_AP > MAX_RS) ? MAX_AP : MAX_RS;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    ctl_state_t state;
    logic       accept;
    logic       access_done;
    logic       float_busy;

    sram_ctl_fsm #(
        .ACC_CYC   (ACC_CYC),
        .SET_CYC   (SET_CYC),
        .PULSE_CYC (PULSE_CYC),
        .REC_CYC   (REC_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .float_busy  (float_busy),
        .state       (state),
        .req_ready   (req_ready),
        .accept      (accept),
        .access_done (access_done)
    );

    sram_ctl_float #(
        .TURN_CYC (TURN_CYC)
    ) u_float (
        .clk        (clk),
        .rst_n      (rst_n),
        .oe_release (access_done),
        .float_busy (float_busy)
    );

    sram_ctl_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .accept      (accept),
        .access_done (access_done),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .mem_dq_in   (mem_dq_in),
        .mem_addr    (mem_addr),
        .mem_dq_out  (mem_dq_out),
        .mem_ce_n    (mem_ce_n),
        .mem_we_n    (mem_we_n),
        .mem_oe_n    (mem_oe_n),
        .mem_dq_oe   (mem_dq_oe),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );

endmodule

// File: rtl/sram_ctl_chk.sv
// Pin-level protocol checker for the strobe controller, bound to the top.
// Assumes the default address and data widths.
module sram_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rd_valid,
    input logic [18:0] mem_addr,
    input logic        mem_ce_n,
    input logic        mem_we_n,
    input logic        mem_oe_n,
    input logic [7:0]  mem_dq_out,
    input logic        mem_dq_oe
);

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R6
    we_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    // R4
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (mem_oe_n && !$past(mem_oe_n)));

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R7
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (mem_oe_n && $past(mem_oe_n)));

    // R9
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

endmodule

bind sram_ctl_top sram_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_ctl_top_bench.sv
// Bench: a 4 ns design clock with grade 5 (25 ns) on the main instance, so
// the phases last ACC=7, SET=1, PULSE=4, REC=3, TURN=3 cycles; a second
// instance at 20 ns / grade 0 where every phase is one cycle.
module sram_ctl_top_bench;

    localparam int EXP_ACC   = 7;  // ceil(25/4)
    localparam int EXP_SET   = 1;
    localparam int EXP_PULSE = 4;  // ceil(15/4)
    localparam int EXP_REC   = 3;  // ceil((25-15)/4)
    localparam int EXP_TURN  = 3;  // ceil(10/4)

    // {write, address, write data, expected read data}
    localparam logic [35:0] VEC [8] = '{
        {1'b1, 19'h00000, 8'h5A, 8'h00},
        {1'b1, 19'h7FFFF, 8'hC3, 8'h00},
        {1'b1, 19'h2A5C3, 8'h01, 8'h00},
        {1'b1, 19'h15A3C, 8'hFF, 8'h00},
        {1'b0, 19'h00000, 8'h00, 8'h5A},
        {1'b0, 19'h7FFFF, 8'h00, 8'hC3},
        {1'b0, 19'h2A5C3, 8'h00, 8'h01},
        {1'b0, 19'h15A3C, 8'h00, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    logic        m_valid = 1'b0;
    logic        m_ready, m_rd_valid, m_ce_n, m_we_n, m_oe_n, m_dq_oe;
    logic [7:0]  m_rd_data, m_dq_out;
    logic [18:0] m_addr;

    int total = 0;
    int bad = 0;
    int gap_run = 0;
    int last_gap = -1;
    logic prev_dq_oe = 1'b0;
    logic [7:0] model_mem [logic [18:0]];

    always #10 clk = ~clk;

    sram_ctl_top #(.CLK_PERIOD_PS(4000), .GRADE(5)) u_sram_ctl_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    sram_ctl_top u_sram_ctl_top_min (
        .clk(clk), .rst_n(rst_n), .req_valid(m_valid), .req_ready(m_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(m_rd_valid), .rd_data(m_rd_data), .mem_addr(m_addr),
        .mem_ce_n(m_ce_n), .mem_we_n(m_we_n), .mem_oe_n(m_oe_n),
        .mem_dq_out(m_dq_out), .mem_dq_oe(m_dq_oe), .mem_dq_in(8'h3C)
    );

    // RAM model: stores on the end of the write strobe, drives on a read.
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n && mem_dq_oe) model_mem[mem_addr] = mem_dq_out;
    end

    always_comb begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_in = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 8'hA5;
        else
            mem_dq_in = 8'h00;
    end

    // Count cycles with output enable high before the bus is driven.
    always @(negedge clk) begin
        if (!rst_n || !mem_oe_n) gap_run = 0;
        else if (!mem_dq_oe) gap_run = gap_run + 1;
        if (mem_dq_oe && !prev_dq_oe) last_gap = gap_run;
        prev_dq_oe = mem_dq_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one request from a negedge and classify every cycle until done.
    task automatic run_txn(input logic w, input logic [18:0] a, input logic [7:0] d,
                           output int n_acc, output int n_set, output int n_pul,
                           output int n_rec, output int n_turn, output logic [7:0] rdat,
                           output logic hold_ok, output logic rdy_ok);
        logic done;
        n_acc = 0; n_set = 0; n_pul = 0; n_rec = 0; n_turn = 0;
        rdat = '0; hold_ok = 1'b1; rdy_ok = 1'b1; done = 1'b0;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        for (int g = 0; g < 200 && !done; g++) begin
            if (!mem_ce_n && mem_addr != a) hold_ok = 1'b0;
            if (mem_dq_oe && mem_dq_out != d) hold_ok = 1'b0;
            if (rd_valid) begin
                rdat = rd_data;
                done = 1'b1;
            end else if (req_ready) begin
                if (!w) rdy_ok = 1'b0;
                done = 1'b1;
            end else if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe) n_acc++;
            else if (!mem_ce_n && !mem_we_n) n_pul++;
            else if (!mem_ce_n && mem_dq_oe && n_pul == 0) n_set++;
            else if (!mem_ce_n && mem_dq_oe) n_rec++;
            else if (mem_ce_n) n_turn++;
            if (!done) @(negedge clk);
        end
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int na, ns, np, nr, nt;
        logic [7:0] rd;
        logic hok, rok;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid && req_ready,
            "R1 reset pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid, req_ready}, 6'b111001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle after reset",
            {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

        // Table walk: writes then read-backs.
        for (int i = 0; i < 8; i++) begin
            run_txn(VEC[i][35], VEC[i][34:16], VEC[i][15:8], na, ns, np, nr, nt, rd, hok, rok);
            chk(hok, "R9 address/data held", int'(hok), 1);
            if (VEC[i][35]) begin
                chk(ns == EXP_SET && np == EXP_PULSE && nr == EXP_REC && na == 0,
                    "R5 write phase lengths", ns*100 + np*10 + nr, EXP_SET*100 + EXP_PULSE*10 + EXP_REC);
                chk(nt == 0, "R8 no turnaround", nt, 0);
            end else begin
                chk(na == EXP_ACC && ns == 0 && np == 0, "R3 read access length", na, EXP_ACC);
                chk(rok, "R2 ready low until read done", int'(rok), 1);
                chk(rd == VEC[i][7:0], "R4 read data", rd, VEC[i][7:0]);
            end
        end

        // R4: valid lasts one cycle (now in the capture cycle).
        @(negedge clk);
        chk(!rd_valid, "R4 valid single cycle", rd_valid, 0);

        // R7: write straight after a read waits out the float window.
        run_txn(1'b0, 19'h00000, 8'h00, na, ns, np, nr, nt, rd, hok, rok);
        chk(rd == 8'h5A, "R4 read before turnaround", rd, 8'h5A);
        run_txn(1'b1, 19'h00077, 8'h99, na, ns, np, nr, nt, rd, hok, rok);
        chk(nt == 1, "R7 turnaround cycles", nt, 1);
        chk(last_gap == EXP_TURN, "R7 oe-high cycles before drive", last_gap, EXP_TURN);
        chk(np == EXP_PULSE, "R5 pulse after turnaround", np, EXP_PULSE);

        // R8: write after the float window has passed starts at once.
        run_txn(1'b0, 19'h00077, 8'h00, na, ns, np, nr, nt, rd, hok, rok);
        chk(rd == 8'h99, "R4 read of turnaround write", rd, 8'h99);
        repeat (6) @(negedge clk);
        run_txn(1'b1, 19'h00078, 8'h42, na, ns, np, nr, nt, rd, hok, rok);
        chk(nt == 0 && ns == EXP_SET, "R8 idle-separated write", nt, 0);
        chk(last_gap >= EXP_TURN, "R7 gap after idle", last_gap, EXP_TURN);

        // R2: a second request held during a write is taken only afterwards.
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00100; req_wdata = 8'h11;
        @(negedge clk);
        req_addr = 19'h00200;
        repeat (3) @(negedge clk);
        chk(!req_ready && mem_addr == 19'h00100, "R2 no accept while busy", mem_addr, 19'h00100);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);

        // R1: reset in the middle of a write strobe returns pins to idle.
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00300; req_wdata = 8'h33;
        for (int g = 0; g < 40 && mem_we_n; g++) @(negedge clk);
        req_valid = 1'b0;
        chk(!mem_we_n, "R6 strobe reached", mem_we_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
            "R1 reset mid-write", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        run_txn(1'b0, 19'h7FFFF, 8'h00, na, ns, np, nr, nt, rd, hok, rok);
        chk(rd == 8'hC3 && na == EXP_ACC, "R3 read after reset", rd, 8'hC3);

        // R10: slow clock, fast grade: one cycle per phase.
        m_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00005;
        while (!m_ready) @(negedge clk);
        @(negedge clk);
        m_valid = 1'b0;
        na = 0;
        for (int g = 0; g < 20 && !m_rd_valid; g++) begin
            if (!m_oe_n) na++;
            @(negedge clk);
        end
        chk(na == 1 && m_rd_data == 8'h3C, "R10 one-cycle read access", na, 1);
        @(negedge clk);
        m_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00006; req_wdata = 8'h6E;
        while (!m_ready) @(negedge clk);
        @(negedge clk);
        m_valid = 1'b0;
        np = 0;
        for (int g = 0; g < 20 && !m_ready; g++) begin
            if (!m_we_n) np++;
            @(negedge clk);
        end
        chk(np == 1, "R10 one-cycle write pulse", np, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule